// File: doc/BRIEF.md
# Converter Serial Readout Interface Model

This block is a synthesizable stand-in for the digital side of a single sampling converter. It serves as a bench peer for host controllers that read such converters over a four-wire serial link. The link has no busy indication. The active-low data-in line `sel_n` doubles as the device select. A rising edge on `conv_req` while the device is deselected starts a conversion. The conversion runs for a fixed number of system clock cycles. The block then holds the converted word, which it took from the parallel `sample_in` port at the start edge, until the host reads it.

A read begins when the host pulls `sel_n` low. The most significant bit appears on `ser_out` at once. Each falling edge of `shift_clk` moves the output down one bit, so every bit stays put across a full serial clock period. The output goes back to high impedance after the last falling edge, or as soon as the host releases `sel_n`, whichever happens first. The tri-state output is modelled as a data bit `ser_out` plus an enable `ser_oe`, so a bench can check that only one device drives a shared line at any time.

All inputs are sampled on the rising edge of `clk`. The states are:
- `ST_IDLE`: no result is held.
- `ST_CONVERT`: the conversion timer is running.
- `ST_ACQUIRE`: a result is held and unread.
- `ST_SHIFT`: a read is in progress.

The transitions are:
- `ST_IDLE` to `ST_CONVERT`: start edge.
- `ST_ACQUIRE` to `ST_CONVERT`: start edge, which replaces the unread result.
- `ST_CONVERT` to `ST_ACQUIRE`: timer done.
- `ST_ACQUIRE` to `ST_SHIFT`: select asserted.
- `ST_SHIFT` to `ST_IDLE`: last falling edge, or select released.

Top module: `adc_serial_emu`

## Requirements
- R1: After reset the block is in `ST_IDLE`, `early_sel_flag` is 0, and with `sel_n` high `ser_oe` is 0.
- R2: A `conv_req` rising edge sampled while `sel_n` is 1, in `ST_IDLE` or `ST_ACQUIRE`, starts a conversion. It captures `sample_in` on that edge, and `ser_oe` is 0 from the next cycle onward. Later changes on `sample_in` do not alter the captured word.
- R3: In `ST_IDLE`, with `sel_n` and `conv_req` both 0, `ser_oe` is 1 and `ser_out` is 0.
- R4: The conversion lasts exactly `CONV_CYCLES` clock edges after the start edge. `ser_oe` stays 0 throughout, even when `sel_n` is low.
- R5: Any edge in `ST_CONVERT` that samples `sel_n` low sets `early_sel_flag`. The flag stays set until the next conversion start clears it.
- R6: Once the conversion is over, `sel_n` low makes `ser_oe` 1 in the same cycle, with bit `DATA_W-1` of the captured word on `ser_out`.
- R7: During a read, each sampled falling edge of `shift_clk` moves `ser_out` to the next lower bit. At all other times, including rising edges, `ser_out` holds its value.
- R8: After the `DATA_W`-th falling edge, the read ends: `ser_oe` is 0 while `conv_req` is held high.
- R9: Raising `sel_n` during a read sets `ser_oe` to 0 in the same cycle and ends the read. A later select with `conv_req` high does not drive the line.
- R10: A `conv_req` rising edge sampled while `sel_n` is 0 starts no conversion.
- R11: A finished result stays readable for any number of cycles until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req | input | 1 | Conversion request; a sampled rising edge starts a conversion |
| sel_n | input | 1 | Data-in line acting as active-low device select |
| shift_clk | input | 1 | Host serial clock; falling edges advance the output bit |
| sample_in | input | DATA_W | Parallel word captured at the conversion start |
| ser_out | output | 1 | Serial data bit, meaningful while `ser_oe` is 1 |
| ser_oe | output | 1 | Output enable; 0 stands for high impedance |
| early_sel_flag | output | 1 | Set when select was asserted during a conversion |

## Verification
`ser_oe` and `ser_out` react to `sel_n` and `conv_req` within the same cycle, so the bench checks them 3 ns after each falling clock edge, once the newly driven inputs have settled. A start edge, the end of a conversion, a falling serial edge and the violation flag each take effect one rising clock edge after the level that causes them is sampled. The conversion ends exactly `CONV_CYCLES` edges after the start edge. A behavioural model updates on every rising edge from the same sampled inputs and is compared on every cycle. Directed checks read whole and partial words, select at the last conversion cycle and at the first cycle after it, and send start edges while the device is selected.

// File: rtl/adc_serial_emu_pkg.sv
package adc_serial_emu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_ACQUIRE = 2'd2,
        ST_SHIFT   = 2'd3
    } emu_state_t;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
    parameter bit RST_VAL = 1'b0,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = prev_q & ~sig;
        end else begin : g_rise
            assign pulse = sig & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CYCLES = 20,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CYCLES - 1);
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
    import adc_serial_emu_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_req,
    input  logic              sel_n,
    input  logic              shift_clk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              early_sel_flag
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

    emu_state_t        state_q, state_d;
    logic [DATA_W-1:0] result_q;
    logic [IDX_W-1:0]  idx_q;
    logic              conv_rise, sclk_fall, conv_done, start;

    adc_edge_det #(.RST_VAL(1'b0), .FALLING(1'b0)) u_conv_edge (
        .clk(clk), .rst_n(rst_n), .sig(conv_req), .pulse(conv_rise)
    );

    adc_edge_det #(.RST_VAL(1'b0), .FALLING(1'b1)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .sig(shift_clk), .pulse(sclk_fall)
    );

    adc_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .done(conv_done)
    );

    assign start = conv_rise && sel_n &&
                   ((state_q == ST_IDLE) || (state_q == ST_ACQUIRE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CONVERT;
            ST_CONVERT: if (conv_done) state_d = ST_ACQUIRE;
            ST_ACQUIRE: begin
                if (start)       state_d = ST_CONVERT;
                else if (!sel_n) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sel_n)                              state_d = ST_IDLE;
                else if (sclk_fall && (idx_q == '0))    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // captured word, bit pointer and violation flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q       <= '0;
            idx_q          <= '0;
            early_sel_flag <= 1'b0;
        end else begin
            if (start) begin
                result_q       <= sample_in;
                early_sel_flag <= 1'b0;
            end
            if ((state_q == ST_CONVERT) && !sel_n)
                early_sel_flag <= 1'b1;
            if ((state_q == ST_ACQUIRE) && !sel_n && !start)
                idx_q <= IDX_TOP;
            if ((state_q == ST_SHIFT) && !sel_n && sclk_fall && (idx_q != '0))
                idx_q <= idx_q - 1'b1;
        end
    end

    // output decode
    always_comb begin
        ser_oe  = 1'b0;
        ser_out = 1'b0;
        unique case (state_q)
            ST_IDLE:    ser_oe = !sel_n && !conv_req;
            ST_CONVERT: ser_oe = 1'b0;
            ST_ACQUIRE: begin
                ser_oe  = !sel_n;
                ser_out = result_q[DATA_W-1];
            end
            ST_SHIFT: begin
                ser_oe  = !sel_n;
                ser_out = result_q[idx_q];
            end
            default: ser_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk
    import adc_serial_emu_pkg::*;
#(
    parameter int DATA_W = 14,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_n,
    input logic             ser_out,
    input logic             ser_oe,
    input logic             early_sel_flag,
    input emu_state_t       state_q,
    input logic [IDX_W-1:0] idx_q,
    input logic             conv_rise,
    input logic             sclk_fall
);
    // R2
    conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_rise && sel_n && (state_q == ST_IDLE || state_q == ST_ACQUIRE))
        |=> (state_q == ST_CONVERT && !ser_oe));

    // R4
    conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT) |-> !ser_oe);

    // R5
    early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && !sel_n) |=> early_sel_flag);

    // R6
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQUIRE && !sel_n && !conv_rise)
        |=> (state_q == ST_SHIFT && idx_q == IDX_W'(DATA_W - 1)));

    // R7
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !sel_n && !sclk_fall)
        |=> (state_q != ST_SHIFT || $stable(ser_out)));

    // R8
    read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !sel_n && sclk_fall && idx_q == '0)
        |=> (state_q == ST_IDLE));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sel_n) |=> (state_q == ST_IDLE));
endmodule

bind adc_serial_emu adc_serial_emu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_out(ser_out),
    .ser_oe(ser_oe), .early_sel_flag(early_sel_flag), .state_q(state_q),
    .idx_q(idx_q), .conv_rise(conv_rise), .sclk_fall(sclk_fall)
);

// File: tb/adc_serial_emu_test.sv
module adc_serial_emu_test;
    localparam int W = 14;
    localparam int C = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_req = 1'b0;
    logic         sel_n = 1'b1;
    logic         shift_clk = 1'b0;
    logic [W-1:0] sample_in = '0;
    wire          ser_out, ser_oe, early_sel_flag;

    adc_serial_emu #(.DATA_W(W), .CONV_CYCLES(C)) uut (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .sel_n(sel_n),
        .shift_clk(shift_clk), .sample_in(sample_in), .ser_out(ser_out),
        .ser_oe(ser_oe), .early_sel_flag(early_sel_flag)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";
    bit    finished = 1'b0;

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // behavioural reference
    bit m_busy, m_have, m_read, m_viol, m_pc, m_ps;
    int m_left;
    bit m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_have = 0; m_read = 0; m_viol = 0;
            m_pc = 0; m_ps = 0; m_left = 0; m_q.delete();
        end else begin
            bit rise, fall;
            rise = conv_req && !m_pc;
            fall = !shift_clk && m_ps;
            if (m_busy) begin
                if (!sel_n) m_viol = 1;
                m_left--;
                if (m_left == 0) begin m_busy = 0; m_have = 1; end
            end else if (m_read) begin
                if (sel_n) begin
                    m_read = 0; m_q.delete();
                end else if (fall) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_read = 0;
                end
            end else if (rise && sel_n) begin
                m_busy = 1; m_left = C; m_viol = 0; m_have = 0;
                m_q.delete();
                for (int i = W - 1; i >= 0; i--) m_q.push_back(sample_in[i]);
            end else if (m_have && !sel_n) begin
                m_have = 0; m_read = 1;
            end
            m_pc = conv_req;
            m_ps = shift_clk;
        end
    end

    always begin
        @(negedge clk);
        #3;
        if (rst_n && !finished) begin
            logic e_oe, e_d;
            e_d = 1'b0;
            if (m_busy)                e_oe = 1'b0;
            else if (m_read || m_have) begin e_oe = !sel_n; e_d = m_q[0]; end
            else                       e_oe = !sel_n && !conv_req;
            check(phase, ser_oe, e_oe, "model enable");
            if (e_oe) check(phase, ser_out, e_d, "model data");
            check(phase, early_sel_flag, m_viol, "model flag");
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_conv(logic [W-1:0] v);
        @(negedge clk);
        sel_n = 1'b1; conv_req = 1'b0; sample_in = v;
        @(negedge clk);
        conv_req = 1'b1;
        @(negedge clk);
        sample_in = ~v;
    endtask

    // caller is at a falling clock edge
    task automatic read_word(logic [W-1:0] v, int nbits);
        sel_n = 1'b0;
        #3;
        check("R6", ser_oe, 1'b1, "enable on select");
        check("R6", ser_out, v[W-1], "msb on select");
        for (int i = W - 1; i >= W - nbits; i--) begin
            @(negedge clk);
            #3;
            check("R7", ser_out, v[i], $sformatf("bit %0d", i));
            shift_clk = 1'b1;
            @(negedge clk);
            #3;
            check("R7", ser_out, v[i], $sformatf("bit %0d after rise", i));
            shift_clk = 1'b0;
        end
        @(negedge clk);
        if (nbits == W) begin
            #3;
            check("R8", ser_oe, 1'b0, "hi-z after last fall");
        end else begin
            sel_n = 1'b1;
            #3;
            check("R9", ser_oe, 1'b0, "hi-z on release");
            @(negedge clk);
            sel_n = 1'b0;
            #3;
            check("R9", ser_oe, 1'b0, "no second read");
        end
        @(negedge clk);
        sel_n = 1'b1;
    endtask

    task automatic finish_run;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        tick(3);
        #3;
        check("R1", ser_oe, 1'b0, "reset enable");
        check("R1", early_sel_flag, 1'b0, "reset flag");
        @(negedge clk);
        rst_n = 1'b1;
        tick(2);

        phase = "R3";
        sel_n = 1'b0;
        #3;
        check("R3", ser_oe, 1'b1, "idle drive");
        check("R3", ser_out, 1'b0, "idle level");
        @(negedge clk);
        sel_n = 1'b1;

        phase = "R2";
        start_conv(14'h2A5C);
        #3;
        check("R2", ser_oe, 1'b0, "hi-z after start");
        tick(C + 2);
        phase = "R7";
        read_word(14'h2A5C, W);

        phase = "R11";
        start_conv(14'h1357);
        tick(3 * C);
        read_word(14'h1357, W);

        phase = "R9";
        start_conv(14'h3E01);
        tick(C + 2);
        read_word(14'h3E01, 5);

        phase = "R4";
        start_conv(14'h0F0F);
        tick(C - 1);
        sel_n = 1'b0;
        #3;
        check("R4", ser_oe, 1'b0, "hi-z on last conversion cycle");
        @(negedge clk);
        #3;
        check("R5", early_sel_flag, 1'b1, "flag after early select");
        read_word(14'h0F0F, W);

        phase = "R5";
        start_conv(14'h0001);
        #3;
        check("R5", early_sel_flag, 1'b0, "flag cleared by start");
        tick(C + 1);
        read_word(14'h0001, W);

        phase = "R10";
        @(negedge clk);
        conv_req = 1'b0; sel_n = 1'b0;
        @(negedge clk);
        conv_req = 1'b1;
        tick(C + 3);
        #3;
        check("R10", ser_oe, 1'b0, "no result after selected start");
        @(negedge clk);
        sel_n = 1'b1;
        tick(2);
        sel_n = 1'b0;
        #3;
        check("R10", ser_oe, 1'b0, "still nothing to read");
        @(negedge clk);
        sel_n = 1'b1;

        phase = "R2";
        start_conv(14'h3FFF);
        tick(C);
        read_word(14'h3FFF, W);

        tick(3);
        finish_run();
    end
endmodule